// File: doc/BRIEF.md
# Luma/Chroma Input Rate Converter

This block sits at the video input of a picture-processing path. It turns a fast luma sample stream and a U/V chroma stream into a 4:1:1 stream at lower rates. Luma arrives at twice the internal luma rate. It passes through a three-tap low-pass filter and only every second filtered value is kept. Chroma arrives on a single bus that alternates between the U and V components. The block splits the two components and halves the rate of each by averaging pairs of samples of the same component. The result is one U and one V value for every four output luma values when the chroma bus runs at half the luma input rate.

Every sample carries its own strobe, so idle cycles between samples are allowed. A line-start pulse sets every phase counter back to the beginning of a line. Each output stream has a flag that marks its first value after a line start, so that downstream logic can align the stream to the picture.

Top module: `yc_rate_conv`

## Requirements
- R1: While reset is asserted, `y_out_vld`, `y_out_sol`, `uv_out_vld` and `uv_out_sol` are 0. Leaving reset has the same effect as a line start.
- R2: Number the luma samples of a line x[0], x[1], … For each k, the filtered luma output k equals floor((x[2k-1] + 2·x[2k] + x[2k+1] + 2) / 4), with x[-1] taken as x[0].
- R3: Luma output k is emitted on the clock edge that follows the edge accepting x[2k+1], with `y_out_vld` high for one cycle. Accepting an even-numbered luma sample never produces an output.
- R4: Chroma samples of a line are numbered c[0], c[1], … Even-numbered samples are U and odd-numbered samples are V. c[0] is the first chroma sample at or after the line start.
- R5: Chroma output j is emitted on the clock edge that follows the edge accepting c[4j+3], with `uv_out_vld` high for one cycle. Its values are U = floor((c[4j] + c[4j+2] + 1) / 2) and V = floor((c[4j+1] + c[4j+3] + 1) / 2).
- R6: When `line_start` is high in a cycle, the luma and chroma sample counts return to zero. A sample accepted in that same cycle becomes sample 0 of the new line. An incomplete luma pair or chroma group left over from the previous line produces no output.
- R7: `y_out_sol` is high together with the first `y_out_vld` after each line start (or after reset), and low at all other times. `uv_out_sol` does the same for `uv_out_vld`.
- R8: Cycles in which a strobe is low do not affect the values produced or their numbering. Only accepted samples advance the counts and the filter history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Line-start pulse; resets all phase counters |
| y_in_vld | input | 1 | Luma input sample strobe |
| y_in | input | W | Luma input sample, unsigned |
| c_in_vld | input | 1 | Chroma input sample strobe |
| c_in | input | W | Interleaved U/V sample, offset binary |
| y_out_vld | output | 1 | Filtered luma output strobe |
| y_out | output | W | Filtered, decimated luma sample |
| y_out_sol | output | 1 | First luma output of the line |
| uv_out_vld | output | 1 | Chroma output strobe |
| u_out | output | W | Averaged U sample |
| v_out | output | W | Averaged V sample |
| uv_out_sol | output | 1 | First chroma output of the line |

## Verification
Both result paths have a single register stage. A luma value is due one edge after its odd-numbered input sample, and a U/V pair is due one edge after the fourth chroma sample of its group. The bench applies one input cycle at a time. It drives the inputs on a falling edge and reads every output on the next falling edge, which falls just after the register edge that carries the result. In that same cycle, a strobe that is required to stay low is checked as well.

// File: rtl/yc_rate_pkg.sv
package yc_rate_pkg;

  // Position inside a group of four interleaved chroma samples.
  typedef enum logic [1:0] {
    CSLOT_U_A = 2'd0,
    CSLOT_V_A = 2'd1,
    CSLOT_U_B = 2'd2,
    CSLOT_V_B = 2'd3
  } cslot_e;

  localparam int unsigned LUMA_TAP_SHIFT = 2;  // taps 1,2,1 sum to 4

endpackage

// File: rtl/yc_sol_tracker.sv
module yc_sol_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic emit,
  output logic first
);

  logic pend_q;
  logic pend_n;
  logic pend_d;

  always_comb begin
    pend_n = line_start | pend_q;
    pend_d = emit ? 1'b0 : pend_n;
    first  = pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/yc_luma_decim.sv
module yc_luma_decim #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_start,
  input  logic         in_vld,
  input  logic [W-1:0] in_smp,
  input  logic         first,
  output logic         emit,
  output logic         out_vld,
  output logic [W-1:0] out_smp,
  output logic         out_sol
);

  import yc_rate_pkg::*;

  localparam int SW = W + int'(LUMA_TAP_SHIFT);

  logic         head_q, head_n, head_d;
  logic         odd_q, odd_n, odd_d;
  logic [W-1:0] d1_q, d1_d;
  logic [W-1:0] d2_q, d2_d;
  logic [SW-1:0] acc;
  logic [W-1:0] filt;
  logic         vld_q, sol_q;
  logic [W-1:0] smp_q;

  always_comb begin
    head_n = line_start | head_q;
    odd_n  = line_start ? 1'b0 : odd_q;
    emit   = in_vld & odd_n;

    acc  = SW'(d2_q) + (SW'(d1_q) << 1) + SW'(in_smp) + SW'(2);
    filt = acc[SW-1:LUMA_TAP_SHIFT];

    head_d = head_n;
    odd_d  = odd_n;
    d1_d   = d1_q;
    d2_d   = d2_q;
    if (in_vld) begin
      head_d = 1'b0;
      odd_d  = ~odd_n;
      d1_d   = in_smp;
      d2_d   = head_n ? in_smp : d1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= 1'b1;
      odd_q  <= 1'b0;
      d1_q   <= '0;
      d2_q   <= '0;
      vld_q  <= 1'b0;
      sol_q  <= 1'b0;
      smp_q  <= '0;
    end else begin
      head_q <= head_d;
      odd_q  <= odd_d;
      if (in_vld) begin
        d1_q <= d1_d;
        d2_q <= d2_d;
      end
      vld_q <= emit;
      sol_q <= emit & first;
      if (emit) begin
        smp_q <= filt;
      end
    end
  end

  assign out_vld = vld_q;
  assign out_smp = smp_q;
  assign out_sol = sol_q;

endmodule

// File: rtl/yc_chroma_decim.sv
module yc_chroma_decim #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_start,
  input  logic         in_vld,
  input  logic [W-1:0] in_smp,
  input  logic         first,
  output logic         emit,
  output logic         out_vld,
  output logic [W-1:0] out_u,
  output logic [W-1:0] out_v,
  output logic         out_sol
);

  import yc_rate_pkg::*;

  cslot_e       slot_q, slot_n, slot_d;
  logic [W-1:0] ua_q, va_q, ub_q;
  logic [W:0]   u_sum, v_sum;
  logic         vld_q, sol_q;
  logic [W-1:0] u_q, v_q;

  always_comb begin
    slot_n = line_start ? CSLOT_U_A : slot_q;
    emit   = in_vld && (slot_n == CSLOT_V_B);

    u_sum = {1'b0, ua_q} + {1'b0, ub_q} + (W+1)'(1);
    v_sum = {1'b0, va_q} + {1'b0, in_smp} + (W+1)'(1);

    slot_d = slot_n;
    if (in_vld) begin
      unique case (slot_n)
        CSLOT_U_A: slot_d = CSLOT_V_A;
        CSLOT_V_A: slot_d = CSLOT_U_B;
        CSLOT_U_B: slot_d = CSLOT_V_B;
        default:   slot_d = CSLOT_U_A;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= CSLOT_U_A;
      ua_q   <= '0;
      va_q   <= '0;
      ub_q   <= '0;
      vld_q  <= 1'b0;
      sol_q  <= 1'b0;
      u_q    <= '0;
      v_q    <= '0;
    end else begin
      slot_q <= slot_d;
      if (in_vld && (slot_n == CSLOT_U_A)) begin
        ua_q <= in_smp;
      end
      if (in_vld && (slot_n == CSLOT_V_A)) begin
        va_q <= in_smp;
      end
      if (in_vld && (slot_n == CSLOT_U_B)) begin
        ub_q <= in_smp;
      end
      vld_q <= emit;
      sol_q <= emit & first;
      if (emit) begin
        u_q <= u_sum[W:1];
        v_q <= v_sum[W:1];
      end
    end
  end

  assign out_vld = vld_q;
  assign out_u   = u_q;
  assign out_v   = v_q;
  assign out_sol = sol_q;

endmodule

// File: rtl/yc_rate_conv.sv
module yc_rate_conv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_start,
  input  logic         y_in_vld,
  input  logic [W-1:0] y_in,
  input  logic         c_in_vld,
  input  logic [W-1:0] c_in,
  output logic         y_out_vld,
  output logic [W-1:0] y_out,
  output logic         y_out_sol,
  output logic         uv_out_vld,
  output logic [W-1:0] u_out,
  output logic [W-1:0] v_out,
  output logic         uv_out_sol
);

  logic y_emit, y_first;
  logic c_emit, c_first;

  yc_sol_tracker u_ysol (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .emit       (y_emit),
    .first      (y_first)
  );

  yc_sol_tracker u_csol (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .emit       (c_emit),
    .first      (c_first)
  );

  yc_luma_decim #(.W(W)) u_luma (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .in_vld     (y_in_vld),
    .in_smp     (y_in),
    .first      (y_first),
    .emit       (y_emit),
    .out_vld    (y_out_vld),
    .out_smp    (y_out),
    .out_sol    (y_out_sol)
  );

  yc_chroma_decim #(.W(W)) u_chroma (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .in_vld     (c_in_vld),
    .in_smp     (c_in),
    .first      (c_first),
    .emit       (c_emit),
    .out_vld    (uv_out_vld),
    .out_u      (u_out),
    .out_v      (v_out),
    .out_sol    (uv_out_sol)
  );

endmodule

// File: rtl/yc_rate_conv_chk.sv
module yc_rate_conv_chk (
  input logic clk,
  input logic rst_n,
  input logic line_start,
  input logic y_in_vld,
  input logic c_in_vld,
  input logic y_out_vld,
  input logic y_out_sol,
  input logic uv_out_vld,
  input logic uv_out_sol
);

  a_r3_luma_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    y_out_vld |-> $past(y_in_vld));

  a_r3_luma_halved: assert property (@(posedge clk) disable iff (!rst_n)
    y_out_vld |=> !y_out_vld);

  a_r5_chroma_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    uv_out_vld |-> $past(c_in_vld));

  a_r5_chroma_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    uv_out_vld |=> !uv_out_vld);

  a_r6_luma_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && y_in_vld) |=> !y_out_vld);

  a_r6_chroma_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && c_in_vld) |=> !uv_out_vld);

  a_r7_luma_flag_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    y_out_sol |-> y_out_vld);

  a_r7_chroma_flag_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    uv_out_sol |-> uv_out_vld);

endmodule

bind yc_rate_conv yc_rate_conv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .y_in_vld   (y_in_vld),
  .c_in_vld   (c_in_vld),
  .y_out_vld  (y_out_vld),
  .y_out_sol  (y_out_sol),
  .uv_out_vld (uv_out_vld),
  .uv_out_sol (uv_out_sol)
);

// File: tb/sim_yc_rate_conv.sv
module sim_yc_rate_conv;

  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         ls, yv, cv;
  logic [W-1:0] yi, ci;
  logic         y_out_vld, y_out_sol, uv_out_vld, uv_out_sol;
  logic [W-1:0] y_out, u_out, v_out;

  yc_rate_conv #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .line_start(ls),
    .y_in_vld(yv), .y_in(yi), .c_in_vld(cv), .c_in(ci),
    .y_out_vld(y_out_vld), .y_out(y_out), .y_out_sol(y_out_sol),
    .uv_out_vld(uv_out_vld), .u_out(u_out), .v_out(v_out),
    .uv_out_sol(uv_out_sol)
  );

  int        n_chk = 0;
  int        n_err = 0;
  int        ycnt, ccnt;
  bit        ysolp, csolp;
  bit        done = 0;
  int        yh [0:4095];
  int        ch [0:4095];
  logic [15:0] lf = 16'hACE1;
  string     tag;

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(bit ok, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", what, tag, act, expv);
    end
  endtask

  // One input cycle: drive at a falling edge, read results at the next one.
  task automatic cyc(bit l, bit a, int y, bit b, int c);
    bit ey, eu;
    int ey_val, eu_val, ev_val;
    ls = l; yv = a; yi = W'(y); cv = b; ci = W'(c);
    @(posedge clk);
    @(negedge clk);
    ey = 0; eu = 0; ey_val = 0; eu_val = 0; ev_val = 0;
    if (l) begin
      ycnt = 0; ccnt = 0; ysolp = 1; csolp = 1;
    end
    if (a) begin
      yh[ycnt] = y;
      if (ycnt % 2 == 1) begin
        ey = 1;
        ey_val = ((ycnt >= 2 ? yh[ycnt-2] : yh[0]) + 2 * yh[ycnt-1] + y + 2) / 4;
      end
      ycnt++;
    end
    if (b) begin
      ch[ccnt] = c;
      if (ccnt % 4 == 3) begin
        eu = 1;
        eu_val = (ch[ccnt-3] + ch[ccnt-1] + 1) / 2;
        ev_val = (ch[ccnt-2] + c + 1) / 2;
      end
      ccnt++;
    end
    chk(y_out_vld == ey, "R3 luma strobe", int'(y_out_vld), int'(ey));
    if (ey && y_out_vld) begin
      chk(int'(y_out) == ey_val, "R2 luma value", int'(y_out), ey_val);
      chk(y_out_sol == ysolp, "R7 luma line flag", int'(y_out_sol), int'(ysolp));
      ysolp = 0;
    end else begin
      chk(y_out_sol == 1'b0, "R7 luma flag idle", int'(y_out_sol), 0);
    end
    chk(uv_out_vld == eu, "R5 chroma strobe", int'(uv_out_vld), int'(eu));
    if (eu && uv_out_vld) begin
      chk(int'(u_out) == eu_val, "R4 R5 U value", int'(u_out), eu_val);
      chk(int'(v_out) == ev_val, "R4 R5 V value", int'(v_out), ev_val);
      chk(uv_out_sol == csolp, "R7 chroma line flag", int'(uv_out_sol), int'(csolp));
      csolp = 0;
    end else begin
      chk(uv_out_sol == 1'b0, "R7 chroma flag idle", int'(uv_out_sol), 0);
    end
    ls = 0; yv = 0; cv = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    tag = "R1";
    rst_n = 1'b0; ls = 0; yv = 0; cv = 0; yi = '0; ci = '0;
    ycnt = 0; ccnt = 0; ysolp = 1; csolp = 1;
    repeat (3) @(negedge clk);
    chk(y_out_vld == 0 && y_out_sol == 0, "R1 luma outputs in reset", int'(y_out_vld), 0);
    chk(uv_out_vld == 0 && uv_out_sol == 0, "R1 chroma outputs in reset", int'(uv_out_vld), 0);
    rst_n = 1'b1;

    // R1: first line begins at reset release, no line_start pulse.
    for (int i = 0; i < 16; i++) begin
      lf = lfsr_next(lf);
      cyc(0, 1, int'(lf[7:0]), (i % 2) == 0, int'(lf[15:8]));
    end

    // R2 R4 R5 R7: sweep of line patterns, chroma at half the luma input rate.
    tag = "R2 sweep";
    for (int p = 0; p < 4; p++) begin
      for (int base = 0; base < 256; base += 17) begin
        for (int i = 0; i < 32; i++) begin
          int yv_i, cv_i;
          lf = lfsr_next(lf);
          case (p)
            0: begin yv_i = (base + 7 * i) % 256; cv_i = (255 - base + 13 * i) % 256; end
            1: begin yv_i = base; cv_i = (i % 2 == 0) ? base : 255 - base; end
            2: begin yv_i = (i % 2 == 0) ? base : 255 - base; cv_i = ((i / 2) % 2 == 0) ? 0 : 255; end
            default: begin yv_i = int'(lf[7:0]); cv_i = int'(lf[15:8]); end
          endcase
          cyc(i == 0, 1, yv_i, (i % 2) == 0, cv_i);
        end
      end
    end

    // R6: short lines that end in the middle of a pair or a group.
    tag = "R6";
    for (int len = 1; len <= 9; len++) begin
      for (int i = 0; i < len; i++) begin
        lf = lfsr_next(lf);
        cyc(i == 0, 1, int'(lf[7:0]), 1, int'(lf[15:8]));
      end
    end
    // R6: line start in a cycle with no sample, samples follow later.
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      lf = lfsr_next(lf);
      cyc(0, 1, int'(lf[7:0]), 1, int'(lf[15:8]));
    end

    // R8: irregular strobes with idle cycles, occasional line starts.
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] v;
      lf = lfsr_next(lf);
      v  = lfsr_next(lf ^ 16'h5A5A);
      cyc(v[15:9] == 0, lf[0] | lf[3], int'(lf[7:0]), v[5] & v[1], int'(v[14:7]));
    end

    done = 1;
    summary();
    $finish;
  end

endmodule